// File: doc/BRIEF.md
# Address Translation Window Table

This block sits on the address path of a memory-mapped slave port that faces a PCIe link. It holds a small table of programmable windows. Each window has a source base, a power-of-two size, a 64-bit translated base and a transaction-type code. A 64-bit address presented with a valid strobe is compared against every window at once. The lowest-numbered window that is switched on and contains the address is chosen. The address bits above that window's size boundary are replaced with the translated base, and the low offset bits are kept.

One clock after the strobe, the block returns the translated address, the chosen window index, its type code and a hit flag. The type code tells the downstream transaction builder whether the access is configuration-space traffic or ordinary memory/IO traffic. When no window matches, the address passes through unchanged and the hit flag is low.

Software programs the table through a simple 32-bit register port with a write strobe, a read strobe and a registered read-data output.

Top module: `atw_table`

## Requirements
- R1: After reset every window is switched off, every register reads 0, `out_valid` and `out_hit` are 0, and lookups miss.
- R2: The registers of window w start at byte offset 0x800 + 0x20*w. The words at +0x0, +0x4, +0x8 and +0xC are the source parameter, the source base bits 63:32, the translated base bits 31:0 and the translated base bits 63:32; each stores all 32 bits. The word at +0x10 stores the type code in bits 3:0 and reads 0 above them. A read strobe returns the value on `reg_rdata` after the next clock edge, and `reg_rdata` holds its value while no read is issued.
- R3: In the source parameter word, bit 0 switches the window on. Bits 6:1 hold a size code s, and the window spans 2^(s+1) bytes. Bits 31:7 are source base bits 31:7; source base bits 6:0 are taken as zero.
- R4: A window hits when it is switched on and address bits 63:s+1 equal source base bits 63:s+1. With s = 63 the window covers the whole address space.
- R5: On a hit, `out_addr` holds translated base bits 63:s+1 joined with incoming address bits s:0.
- R6: When several windows hit, the lowest-numbered one wins, and its index is driven on `out_win`.
- R7: When no window hits, `out_hit` is 0, `out_addr` equals the incoming address, and `out_tid` and `out_win` are 0.
- R8: `out_tid` carries bits 3:0 of the winning window's type word. Code 0 marks memory/IO traffic and code 1 marks configuration traffic.
- R9: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high, and the result appears in that same cycle. While `in_valid` is low, `out_valid` is 0 and the other result outputs hold their values.
- R10: A register write takes effect for lookups presented from the next cycle on; a lookup in the same cycle as the write uses the old table. Writes to word offsets other than the five listed, or to window indices of 8 and above, change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 64 | Address to translate |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_hit | output | 1 | A window matched |
| out_addr | output | 64 | Translated or passed-through address |
| out_tid | output | 4 | Type code of the winning window |
| out_win | output | 3 | Index of the winning window |

## Verification
A corrupted window register shows up in the very next lookup that falls into that window, or into a neighbouring one it now overlaps: the wrong hit flag, window index or translated high bits appear one cycle after the strobe. A faulty size decode moves the boundary between translated and kept bits, so the bench probes addresses just inside and just outside each window. It also checks the offset bits of every translated result. A priority fault only shows when windows overlap, so overlapping windows are set up on purpose, and one of them is then switched off to confirm the hand-over to the next window.

// File: rtl/atw_pkg.sv
package atw_pkg;
    localparam int ADDR_W   = 64;
    localparam int RDATA_W  = 32;
    localparam int SIZE_W   = 6;
    localparam int TID_W    = 4;
    localparam int BASE_LSB = 7;

    localparam logic [TID_W-1:0] TID_MEM = TID_W'(0);
    localparam logic [TID_W-1:0] TID_CFG = TID_W'(1);

    // Raw storage of one window, as software wrote it
    typedef struct packed {
        logic [RDATA_W-1:0] src_param;
        logic [RDATA_W-1:0] src_hi;
        logic [RDATA_W-1:0] dst_lo;
        logic [RDATA_W-1:0] dst_hi;
        logic [TID_W-1:0]   tid;
    } win_regs_t;

    typedef enum logic [2:0] {
        SEL_SRCP,
        SEL_SRCH,
        SEL_DSTL,
        SEL_DSTH,
        SEL_TID,
        SEL_NONE
    } word_sel_e;

    // Ones over the offset bits kept from the incoming address
    function automatic logic [ADDR_W-1:0] span_mask(input logic [SIZE_W-1:0] code);
        logic [SIZE_W:0] n;
        n = {1'b0, code} + (SIZE_W+1)'(1);
        if (n >= (SIZE_W+1)'(ADDR_W)) begin
            return '1;
        end
        return (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction
endpackage

// File: rtl/atw_regfile.sv
module atw_regfile
    import atw_pkg::*;
#(
    parameter int NUM_WIN    = 8,
    parameter int REG_AW     = 12,
    parameter int REG_BASE   = 'h800,
    parameter int WIN_STRIDE = 'h20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic                      reg_re,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [RDATA_W-1:0]        reg_wdata,
    output logic [RDATA_W-1:0]        reg_rdata,
    output win_regs_t [NUM_WIN-1:0]   win_cfg
);
    localparam int STRIDE_LG = $clog2(WIN_STRIDE);
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        win_regs_t [NUM_WIN-1:0] win;
        logic [RDATA_W-1:0]      rdata;
    } rf_state_t;

    rf_state_t          st_d, st_q;
    logic [REG_AW-1:0]  off;
    logic [REG_AW-1:0]  idx_full;
    logic               in_block;
    logic [IDX_W-1:0]   idx;
    word_sel_e          sel;
    logic [RDATA_W-1:0] rd_val;

    // Address decode: window index and word within the window
    always_comb begin
        off      = reg_addr - REG_AW'(REG_BASE);
        idx_full = off >> STRIDE_LG;
        in_block = (reg_addr >= REG_AW'(REG_BASE)) && (idx_full < REG_AW'(NUM_WIN));
        idx      = idx_full[IDX_W-1:0];
        sel      = SEL_NONE;
        if (in_block) begin
            case (off[STRIDE_LG-1:0])
                STRIDE_LG'('h00): sel = SEL_SRCP;
                STRIDE_LG'('h04): sel = SEL_SRCH;
                STRIDE_LG'('h08): sel = SEL_DSTL;
                STRIDE_LG'('h0C): sel = SEL_DSTH;
                STRIDE_LG'('h10): sel = SEL_TID;
                default:          sel = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        st_d   = st_q;
        rd_val = '0;
        case (sel)
            SEL_SRCP: rd_val = st_q.win[idx].src_param;
            SEL_SRCH: rd_val = st_q.win[idx].src_hi;
            SEL_DSTL: rd_val = st_q.win[idx].dst_lo;
            SEL_DSTH: rd_val = st_q.win[idx].dst_hi;
            SEL_TID:  rd_val = RDATA_W'(st_q.win[idx].tid);
            default:  rd_val = '0;
        endcase
        if (reg_re) begin
            st_d.rdata = rd_val;
        end
        if (reg_we) begin
            case (sel)
                SEL_SRCP: st_d.win[idx].src_param = reg_wdata;
                SEL_SRCH: st_d.win[idx].src_hi    = reg_wdata;
                SEL_DSTL: st_d.win[idx].dst_lo    = reg_wdata;
                SEL_DSTH: st_d.win[idx].dst_hi    = reg_wdata;
                SEL_TID:  st_d.win[idx].tid       = reg_wdata[TID_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign win_cfg   = st_q.win;

    // R10: holes in the map read as zero
    p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && sel == SEL_NONE) |=> (reg_rdata == '0));

    // R2: read data is held between reads
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));
endmodule

// File: rtl/atw_window_match.sv
module atw_window_match
    import atw_pkg::*;
(
    input  win_regs_t          cfg_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               hit_o,
    output logic [ADDR_W-1:0]  xlat_o,
    output logic [TID_W-1:0]   tid_o
);
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] dst_base;

    always_comb begin
        keep_mask = span_mask(cfg_i.src_param[SIZE_W:1]);
        src_base  = {cfg_i.src_hi, cfg_i.src_param[RDATA_W-1:BASE_LSB], BASE_LSB'(0)};
        dst_base  = {cfg_i.dst_hi, cfg_i.dst_lo};
        hit_o     = cfg_i.src_param[0] && (((addr_i ^ src_base) & ~keep_mask) == '0);
        xlat_o    = (dst_base & ~keep_mask) | (addr_i & keep_mask);
        tid_o     = cfg_i.tid;
    end
endmodule

// File: rtl/atw_pick.sv
module atw_pick
    import atw_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_WIN-1:0]              hits_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xlat_i,
    input  logic [NUM_WIN-1:0][TID_W-1:0]   tid_i,
    input  logic [ADDR_W-1:0]               addr_i,
    output logic                            any_o,
    output logic [IDX_W-1:0]                idx_o,
    output logic [ADDR_W-1:0]               addr_o,
    output logic [TID_W-1:0]                tid_o
);
    // Scan from the top so the lowest index is written last and wins
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        addr_o = addr_i;
        tid_o  = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits_i[w]) begin
                any_o  = 1'b1;
                idx_o  = IDX_W'(w);
                addr_o = xlat_i[w];
                tid_o  = tid_i[w];
            end
        end
    end
endmodule

// File: rtl/atw_table.sv
module atw_table
    import atw_pkg::*;
#(
    parameter int NUM_WIN    = 8,
    parameter int REG_AW     = 12,
    parameter int REG_BASE   = 'h800,
    parameter int WIN_STRIDE = 'h20,
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               in_valid,
    input  logic [63:0]        in_addr,
    output logic               out_valid,
    output logic               out_hit,
    output logic [63:0]        out_addr,
    output logic [3:0]         out_tid,
    output logic [IDX_W-1:0]   out_win
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [TID_W-1:0]  tid;
        logic [IDX_W-1:0]  win;
    } out_state_t;

    win_regs_t [NUM_WIN-1:0]             win_cfg;
    logic [NUM_WIN-1:0]                  hits;
    logic [NUM_WIN-1:0][ADDR_W-1:0]      xlat;
    logic [NUM_WIN-1:0][TID_W-1:0]       tids;
    logic                                any_hit;
    logic [IDX_W-1:0]                    pick_idx;
    logic [ADDR_W-1:0]                   pick_addr;
    logic [TID_W-1:0]                    pick_tid;
    out_state_t                          o_d, o_q;

    atw_regfile #(
        .NUM_WIN    (NUM_WIN),
        .REG_AW     (REG_AW),
        .REG_BASE   (REG_BASE),
        .WIN_STRIDE (WIN_STRIDE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_cfg   (win_cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        atw_window_match u_match (
            .cfg_i  (win_cfg[g]),
            .addr_i (in_addr),
            .hit_o  (hits[g]),
            .xlat_o (xlat[g]),
            .tid_o  (tids[g])
        );
    end

    atw_pick #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) u_pick (
        .hits_i (hits),
        .xlat_i (xlat),
        .tid_i  (tids),
        .addr_i (in_addr),
        .any_o  (any_hit),
        .idx_o  (pick_idx),
        .addr_o (pick_addr),
        .tid_o  (pick_tid)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = in_valid;
        if (in_valid) begin
            o_d.hit  = any_hit;
            o_d.addr = pick_addr;
            o_d.tid  = pick_tid;
            o_d.win  = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_hit   = o_q.hit;
    assign out_addr  = o_q.addr;
    assign out_tid   = o_q.tid;
    assign out_win   = o_q.win;

    // R9: one-cycle result latency
    p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: idle cycles keep the last result
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_hit) && $stable(out_win)));

    // R7: a miss passes the address through
    p_miss_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_hit) |=> (!out_hit && out_addr == $past(in_addr) && out_tid == '0 && out_win == '0));

    // R6: the chosen window really hits
    p_winner_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hits[pick_idx]);

    // R6: no lower-numbered window also hits
    p_no_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hits & ((NUM_WIN'(1) << pick_idx) - NUM_WIN'(1))) == '0));

    // R4: a hit is reported with the window found at request time
    p_hit_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_hit) |=> (out_hit && out_win == $past(pick_idx)));
endmodule

// File: tb/atw_table_tb_top.sv
module atw_table_tb_top;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [63:0] out_addr;
    logic [3:0]  out_tid;
    logic [2:0]  out_win;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] m_sp  [NW];
    logic [31:0] m_sh  [NW];
    logic [31:0] m_dl  [NW];
    logic [31:0] m_dh  [NW];
    logic [3:0]  m_tid [NW];

    always #10 clk = ~clk;

    atw_table dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_addr  (out_addr),
        .out_tid   (out_tid),
        .out_win   (out_win)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        int w;
        if (a >= 12'h800 && a < 12'h900) begin
            w = int'((a - 12'h800) >> 5);
            case (a[4:0])
                5'h00: m_sp[w]  = d;
                5'h04: m_sh[w]  = d;
                5'h08: m_dl[w]  = d;
                5'h0C: m_dh[w]  = d;
                5'h10: m_tid[w] = d[3:0];
                default: ;
            endcase
        end
    endfunction

    function automatic void model(input logic [63:0] a, output logic h, output logic [63:0] xa,
                                  output logic [3:0] t, output logic [2:0] wi);
        logic [6:0]  n;
        logic [63:0] msk;
        logic [63:0] base;
        h = 1'b0; xa = a; t = '0; wi = '0;
        for (int w = 0; w < NW; w++) begin
            n    = {1'b0, m_sp[w][6:1]} + 7'd1;
            msk  = (n >= 7'd64) ? '1 : ((64'd1 << n) - 64'd1);
            base = {m_sh[w], m_sp[w][31:7], 7'b0};
            if (!h && m_sp[w][0] && (((a ^ base) & ~msk) == '0)) begin
                h  = 1'b1;
                xa = ({m_dh[w], m_dl[w]} & ~msk) | (a & msk);
                t  = m_tid[w];
                wi = 3'(w);
            end
        end
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        model_write(a, d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look(input logic [63:0] a, input string req);
        logic h; logic [63:0] xa; logic [3:0] t; logic [2:0] wi;
        model(a, h, xa, t, wi);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {req, " valid R9"}, 64'(out_valid), 64'd1);
        chk(out_hit == h, {req, " hit"}, 64'(out_hit), 64'(h));
        chk(out_addr == xa, {req, " addr"}, out_addr, xa);
        chk(out_tid == t, {req, " tid R8"}, 64'(out_tid), 64'(t));
        chk(out_win == wi, {req, " win"}, 64'(out_win), 64'(wi));
    endtask

    function automatic logic [11:0] wa(input int w, input int o);
        return 12'(12'h800 + w * 12'h20 + o);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic h; logic [63:0] xa; logic [3:0] t; logic [2:0] wi;
        logic [63:0] last;
        void'($urandom(32'd7301));
        for (int w = 0; w < NW; w++) begin
            m_sp[w] = '0; m_sh[w] = '0; m_dl[w] = '0; m_dh[w] = '0; m_tid[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 0);
        chk(out_hit == 1'b0, "R1 out_hit", 64'(out_hit), 0);
        rd_chk(wa(0, 0), 0, "R1 read src param");
        rd_chk(wa(7, 'h10), 0, "R1 read tid");
        look(64'h0000_0009_4123_4567, "R1 R7 empty table");

        // Window 0: configuration window, 256 MiB at 0x9_4000_0000
        wr(wa(0, 'h0), 32'h4000_0037);
        wr(wa(0, 'h4), 32'h0000_0009);
        wr(wa(0, 'h8), 32'h0);
        wr(wa(0, 'hC), 32'h0);
        wr(wa(0, 'h10), 32'h1);
        look(64'h0000_0009_4123_4567, "R3 R4 R5 cfg window");
        chk(out_addr == 64'h0000_0000_0123_4567, "R5 directed addr", out_addr, 64'h0123_4567);
        chk(out_tid == 4'd1, "R8 config code", 64'(out_tid), 1);
        look(64'h0000_0009_4FFF_FFFF, "R4 top edge inside");
        look(64'h0000_0009_3FFF_FFFF, "R4 R7 below window");
        chk(out_hit == 1'b0 && out_addr == 64'h9_3FFF_FFFF, "R7 pass through", out_addr, 64'h9_3FFF_FFFF);
        look(64'h0000_0009_5000_0000, "R4 R7 above window");

        // R9: idle cycle holds result, valid low
        last = out_addr;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle valid", 64'(out_valid), 0);
        chk(out_addr == last, "R9 idle hold", out_addr, last);

        // Overlapping windows 3 and 5
        wr(wa(3, 'h0), 32'h0000_0027);
        wr(wa(3, 'h4), 32'h0000_0030);
        wr(wa(3, 'h8), 32'hC000_0000);
        wr(wa(5, 'h0), 32'h0000_003F);
        wr(wa(5, 'h4), 32'h0000_0030);
        wr(wa(5, 'hC), 32'h0000_0001);
        look(64'h0000_0030_0001_2345, "R6 overlap low wins");
        chk(out_win == 3'd3 && out_addr == 64'hC001_2345, "R6 directed win3", out_addr, 64'hC001_2345);
        chk(out_tid == 4'd0, "R8 memory code", 64'(out_tid), 0);
        look(64'h0000_0030_0020_0000, "R6 only upper window");
        wr(wa(3, 'h0), 32'h0000_0026);
        look(64'h0000_0030_0001_2345, "R3 switch-off hands over");
        chk(out_win == 3'd5 && out_addr == 64'h1_0001_2345, "R3 directed win5", out_addr, 64'h1_0001_2345);

        // Whole-space window at the highest index
        wr(wa(7, 'h0), 32'h0000_007F);
        wr(wa(7, 'hC), 32'hFFFF_0000);
        look(64'h1234_5678_9ABC_DEF0, "R4 whole space");
        chk(out_hit && out_win == 3'd7 && out_addr == 64'h1234_5678_9ABC_DEF0, "R4 full span keeps addr",
            out_addr, 64'h1234_5678_9ABC_DEF0);

        // R2: readback
        wr(wa(3, 'h10), 32'hFFFF_FFF1);
        rd_chk(wa(3, 'h10), 32'h1, "R2 tid upper bits zero");
        rd_chk(wa(0, 'h0), 32'h4000_0037, "R2 src param");
        rd_chk(wa(5, 'hC), 32'h1, "R2 dst hi");
        rd_chk(wa(3, 'h8), 32'hC000_0000, "R2 dst lo");

        // R10: holes and out-of-range windows
        wr(wa(0, 'h14), 32'hDEAD_BEEF);
        rd_chk(wa(0, 'h14), 0, "R10 hole read");
        wr(12'h900, 32'h0000_0001);
        rd_chk(12'h900, 0, "R10 window 8 read");
        rd_chk(12'h7FC, 0, "R10 below base read");
        rd_chk(wa(0, 'h0), 32'h4000_0037, "R10 neighbour untouched");
        look(64'h0000_0009_4123_4567, "R10 table intact");

        // R10: same-cycle write and lookup uses old table
        model(64'h0000_0009_4000_0010, h, xa, t, wi);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = wa(0, 'h0); reg_wdata = 32'h4000_0036;
        in_valid = 1'b1; in_addr = 64'h0000_0009_4000_0010;
        model_write(wa(0, 'h0), 32'h4000_0036);
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        chk(out_hit == h && out_win == wi && out_addr == xa, "R10 same-cycle old table", out_addr, xa);
        look(64'h0000_0009_4000_0010, "R10 next lookup new table");

        // Random phase
        for (int it = 0; it < 60; it++) begin
            int w;
            logic [31:0] sp;
            w  = int'($urandom_range(NW - 1, 0));
            sp = {$urandom(), 7'b0} | 32'(($urandom_range(40, 6)) << 1) | 32'($urandom_range(3, 0) != 0);
            wr(wa(w, 'h0), sp);
            wr(wa(w, 'h4), 32'($urandom_range(3, 0)));
            wr(wa(w, 'h8), $urandom());
            wr(wa(w, 'hC), $urandom());
            wr(wa(w, 'h10), 32'($urandom_range(1, 0)));
            for (int k = 0; k < 6; k++) begin
                int v;
                logic [63:0] a;
                v = int'($urandom_range(NW - 1, 0));
                a = {m_sh[v], m_sp[v][31:7], 7'b0} ^ ({32'($urandom()), 32'($urandom())} >> $urandom_range(63, 20));
                if (k == 5) a = {$urandom(), $urandom()};
                look(a, "R4 R5 R6 R7 random");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule